// File: doc/BRIEF.md
# Stream Segmenter With Lifecycle Strobes

This block cuts an unbounded stream of samples into finite segments. Each input sample arrives on a valid/ready handshake together with a control bit. A run of consecutive samples whose control bit is high forms one segment. Samples whose control bit is low are consumed and discarded. The forwarded samples leave on a valid/ready output and carry a marker for the first beat of a segment and a marker for the last beat.

Alongside the data, the block drives one-cycle lifecycle strobes for downstream processing stages:

- a start strobe when the block is first enabled;
- a reset strobe when a segment opens;
- an apply strobe for every in-segment sample that is taken;
- an end-of-segment strobe when a segment closes;
- a terminate strobe once a flush request has closed everything.

Whether a sample is the last of its segment is only known when the following sample, or a flush, arrives. For that reason the newest in-segment sample waits in a one-entry holding stage until its fate is decided.

Top module: `stream_segmenter`

## Requirements
- R1: After reset, and while `enable` has never been high, `in_ready`, `out_valid` and all five strobes are low.
- R2: `life_start` is high for exactly one cycle, in the first cycle `enable` is high after reset. It never fires again before the next reset, and `in_ready` stays low in that cycle.
- R3: A taken sample with `in_ctrl`=1 raises `life_reset` in the same cycle if no segment is open. That sample later leaves with `out_first`=1.
- R4: `life_apply` is high in exactly those cycles in which a sample with `in_ctrl`=1 is taken (`in_valid` and `in_ready` both high).
- R5: A taken sample with `in_ctrl`=0 is never forwarded. It closes any open segment.
- R6: A held sample is presented on the output in a cycle where `in_valid` is high. It is released when the next sample is taken. `out_last` equals the inverse of that next sample's `in_ctrl`, and `life_end` is high in exactly the cycles in which a beat with `out_last`=1 is transferred.
- R7: A one-sample segment transfers one beat with both `out_first` and `out_last` set. Its `life_reset` comes in an earlier cycle than its `life_end`.
- R8: While a sample is held and `out_ready` is low, `in_ready` is low and no strobe fires. Raising `out_ready` lets the transfer and the next intake happen in the same cycle.
- R9: A `flush` in the running phase blocks input in that cycle. In the next cycle, any held sample is presented with `out_last`=1, and `life_end` fires when it is taken. `life_term` fires one cycle after the segment is closed, or two cycles after the flush if no segment was open.
- R10: After `life_term`, `in_ready`, `out_valid` and all strobes stay low until reset, whatever the inputs.
- R11: Forwarded data words are unchanged and leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Leaves the idle phase and fires the start strobe |
| flush | input | 1 | Closes any open segment, then terminates |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take the input sample |
| in_data | input | DATA_W | Input sample word |
| in_ctrl | input | 1 | Segment membership bit of the input sample |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream can take the output beat |
| out_data | output | DATA_W | Output sample word |
| out_first | output | 1 | Beat opens a segment |
| out_last | output | 1 | Beat closes a segment |
| life_start | output | 1 | One-cycle start strobe |
| life_reset | output | 1 | One-cycle strobe at segment open |
| life_apply | output | 1 | One-cycle strobe per taken in-segment sample |
| life_end | output | 1 | One-cycle strobe at segment close |
| life_term | output | 1 | One-cycle terminate strobe |

## Verification
The apply strobe for a newly taken sample and the transfer of the previously held sample land in the same cycle whenever a segment continues. The same is true of the end-of-segment strobe and the transfer of a closing beat. The bench provokes the first case by feeding back-to-back control-high samples, both with `out_ready` held high and after a stall released by raising `out_ready`. It provokes the second by following a segment with a control-low sample. In each of those cycles it checks the strobes and the output beat (data, first and last markers) together against hand-derived expectations.

// File: rtl/seg_pkg.sv
package seg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RUN   = 3'd1,
      PH_CLOSE = 3'd2,
      PH_TERM  = 3'd3,
      PH_DONE  = 3'd4
   } seg_phase_e;

   // One cycle's worth of boundary decisions.
   typedef struct packed {
      logic in_ready;
      logic emit;
      logic last;
      logic load;
      logic empty;
      logic open;
      logic apply;
      logic eos;
   } seg_step_t;

endpackage

// File: rtl/seg_phase_fsm.sv
module seg_phase_fsm
   import seg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       flush,
   input  logic       hold_valid,
   input  logic       out_ready,
   output seg_phase_e phase,
   output logic       start_pulse,
   output logic       term_pulse,
   output logic       close_emit,
   output logic       close_done
);

   seg_phase_e phase_nx;

   always_comb begin
      phase_nx    = phase;
      start_pulse = 1'b0;
      term_pulse  = 1'b0;
      close_emit  = 1'b0;
      close_done  = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (enable) begin
               start_pulse = 1'b1;
               phase_nx    = PH_RUN;
            end
         end
         PH_RUN: begin
            if (flush) phase_nx = PH_CLOSE;
         end
         PH_CLOSE: begin
            if (hold_valid) begin
               close_emit = 1'b1;
               if (out_ready) begin
                  close_done = 1'b1;
                  phase_nx   = PH_TERM;
               end
            end else begin
               phase_nx = PH_TERM;
            end
         end
         PH_TERM: begin
            term_pulse = 1'b1;
            phase_nx   = PH_DONE;
         end
         PH_DONE: phase_nx = PH_DONE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/seg_boundary.sv
module seg_boundary
   import seg_pkg::*;
(
   input  seg_phase_e phase,
   input  logic       flush,
   input  logic       in_valid,
   input  logic       in_ctrl,
   input  logic       hold_valid,
   input  logic       out_ready,
   input  logic       close_emit,
   input  logic       close_done,
   output seg_step_t  step
);

   logic take;

   always_comb begin
      step = '0;
      take = 1'b0;
      if (phase == PH_RUN && !flush) begin
         step.in_ready = !hold_valid || out_ready;
         take          = in_valid && step.in_ready;
         step.emit     = hold_valid && in_valid;
         step.last     = hold_valid && in_valid && !in_ctrl;
         step.load     = take && in_ctrl;
         step.empty    = take && !in_ctrl;
         step.open     = take && in_ctrl && !hold_valid;
         step.apply    = take && in_ctrl;
         step.eos      = take && hold_valid && !in_ctrl;
      end else if (close_emit) begin
         step.emit  = 1'b1;
         step.last  = 1'b1;
         step.eos   = close_done;
         step.empty = close_done;
      end
   end

endmodule

// File: rtl/seg_hold_buf.sv
module seg_hold_buf #(
   parameter int DATA_W      = 8,
   parameter bit CLEAR_EMPTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_first,
   input  logic [DATA_W-1:0] load_data,
   input  logic              clear,
   output logic              valid,
   output logic              first,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         first <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         first <= load_first;
      end else if (clear) begin
         valid <= 1'b0;
         first <= 1'b0;
      end
   end

   generate
      if (CLEAR_EMPTY) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n)     data <= '0;
            else if (load)  data <= load_data;
            else if (clear) data <= '0;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n)    data <= '0;
            else if (load) data <= load_data;
         end
      end
   endgenerate

endmodule

// File: rtl/stream_segmenter.sv
module stream_segmenter
   import seg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit CLEAR_EMPTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              flush,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_ctrl,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_first,
   output logic              out_last,
   output logic              life_start,
   output logic              life_reset,
   output logic              life_apply,
   output logic              life_end,
   output logic              life_term
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("stream_segmenter: DATA_W must be at least 1");
      end
   endgenerate

   seg_phase_e phase;
   seg_step_t  step;
   logic       hold_valid;
   logic       hold_first;
   logic       close_emit;
   logic       close_done;
   logic       start_pulse;
   logic       term_pulse;

   seg_phase_fsm u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .flush       (flush),
      .hold_valid  (hold_valid),
      .out_ready   (out_ready),
      .phase       (phase),
      .start_pulse (start_pulse),
      .term_pulse  (term_pulse),
      .close_emit  (close_emit),
      .close_done  (close_done)
   );

   seg_boundary u_bound (
      .phase      (phase),
      .flush      (flush),
      .in_valid   (in_valid),
      .in_ctrl    (in_ctrl),
      .hold_valid (hold_valid),
      .out_ready  (out_ready),
      .close_emit (close_emit),
      .close_done (close_done),
      .step       (step)
   );

   seg_hold_buf #(
      .DATA_W      (DATA_W),
      .CLEAR_EMPTY (CLEAR_EMPTY)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (step.load),
      .load_first (step.open),
      .load_data  (in_data),
      .clear      (step.empty),
      .valid      (hold_valid),
      .first      (hold_first),
      .data       (out_data)
   );

   assign in_ready   = step.in_ready;
   assign out_valid  = step.emit;
   assign out_first  = step.emit && hold_first;
   assign out_last   = step.last;
   assign life_start = start_pulse;
   assign life_reset = step.open;
   assign life_apply = step.apply;
   assign life_end   = step.eos;
   assign life_term  = term_pulse;

endmodule

// File: rtl/seg_checker.sv
module seg_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic in_ctrl,
   input logic out_valid,
   input logic out_ready,
   input logic out_last,
   input logic life_start,
   input logic life_reset,
   input logic life_apply,
   input logic life_end,
   input logic life_term
);

   logic started;
   logic seg_open;
   logic term_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started   <= 1'b0;
         seg_open  <= 1'b0;
         term_seen <= 1'b0;
      end else begin
         if (life_start) started <= 1'b1;
         if (life_reset) seg_open <= 1'b1;
         else if (life_end) seg_open <= 1'b0;
         if (life_term) term_seen <= 1'b1;
      end
   end

   // R1: lifecycle strobes other than apply never coincide
   a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({life_start, life_reset, life_end, life_term}));

   // R2: start fires once; no intake before it
   a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> !life_start);
   a_r2_no_intake_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !in_ready);

   // R3: a segment opens only when none is open
   a_r3_reset_opens: assert property (@(posedge clk) disable iff (!rst_n)
      life_reset |-> !seg_open);

   // R4: apply only on a taken in-segment sample
   a_r4_apply_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      life_apply |-> (in_valid && in_ready && in_ctrl));

   // R6: end-of-segment coincides with a transferred last beat, both ways
   a_r6_end_has_last: assert property (@(posedge clk) disable iff (!rst_n)
      life_end |-> (out_valid && out_ready && out_last && seg_open));
   a_r6_last_has_end: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |-> life_end);

   // R8: a stalled output blocks intake
   a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R9: terminate only with no open segment
   a_r9_term_closed: assert property (@(posedge clk) disable iff (!rst_n)
      life_term |-> !seg_open);

   // R10: silence after terminate
   a_r10_quiet_after_term: assert property (@(posedge clk) disable iff (!rst_n)
      term_seen |-> !(in_ready || out_valid || life_start || life_reset ||
                      life_apply || life_end || life_term));

endmodule

bind stream_segmenter seg_checker i_seg_checker (.*);

// File: tb/test_stream_segmenter.sv
module test_stream_segmenter;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int NVEC       = 18;
   localparam int VW         = 34;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          enable, flush, in_valid, in_ctrl, out_ready;
   logic [DW-1:0] in_data;
   logic          in_ready, out_valid, out_first, out_last;
   logic [DW-1:0] out_data;
   logic          life_start, life_reset, life_apply, life_end, life_term;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stream_segmenter #(.DATA_W(DW)) i_stream_segmenter (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .flush      (flush),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_ctrl    (in_ctrl),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_first  (out_first),
      .out_last   (out_last),
      .life_start (life_start),
      .life_reset (life_reset),
      .life_apply (life_apply),
      .life_end   (life_end),
      .life_term  (life_term)
   );

   // {req, en fl iv ic, data, out_ready, exp in_ready out_valid, exp data,
   //  exp first last, exp start reset apply end term}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {4'd1,  4'b0000, 8'h00, 1'b1, 2'b00, 8'h00, 2'b00, 5'b00000}, // R1 idle
      {4'd2,  4'b1011, 8'h11, 1'b1, 2'b00, 8'h00, 2'b00, 5'b10000}, // R2 start
      {4'd3,  4'b1011, 8'h11, 1'b1, 2'b10, 8'h00, 2'b00, 5'b01100}, // R3 open
      {4'd6,  4'b1011, 8'h22, 1'b1, 2'b11, 8'h11, 2'b10, 5'b00100}, // R6 continue
      {4'd6,  4'b1010, 8'h99, 1'b1, 2'b11, 8'h22, 2'b01, 5'b00010}, // R6 close
      {4'd5,  4'b1010, 8'h98, 1'b1, 2'b10, 8'h00, 2'b00, 5'b00000}, // R5 drop
      {4'd7,  4'b1011, 8'h33, 1'b1, 2'b10, 8'h00, 2'b00, 5'b01100}, // R7 open
      {4'd7,  4'b1010, 8'h97, 1'b1, 2'b11, 8'h33, 2'b11, 5'b00010}, // R7 single
      {4'd3,  4'b1011, 8'h44, 1'b1, 2'b10, 8'h00, 2'b00, 5'b01100}, // R3 open
      {4'd8,  4'b1011, 8'h55, 1'b0, 2'b01, 8'h44, 2'b10, 5'b00000}, // R8 stall
      {4'd8,  4'b1011, 8'h55, 1'b1, 2'b11, 8'h44, 2'b10, 5'b00100}, // R8 release
      {4'd11, 4'b1000, 8'h00, 1'b1, 2'b10, 8'h00, 2'b00, 5'b00000}, // R11 idle gap
      {4'd9,  4'b1111, 8'h66, 1'b1, 2'b00, 8'h00, 2'b00, 5'b00000}, // R9 flush
      {4'd9,  4'b1010, 8'h66, 1'b0, 2'b01, 8'h55, 2'b01, 5'b00000}, // R9 close stall
      {4'd9,  4'b1000, 8'h00, 1'b1, 2'b01, 8'h55, 2'b01, 5'b00010}, // R9 close
      {4'd9,  4'b1000, 8'h00, 1'b1, 2'b00, 8'h00, 2'b00, 5'b00001}, // R9 term
      {4'd10, 4'b1011, 8'h77, 1'b1, 2'b00, 8'h00, 2'b00, 5'b00000}, // R10 quiet
      {4'd10, 4'b1111, 8'h78, 1'b1, 2'b00, 8'h00, 2'b00, 5'b00000}  // R10 quiet
   };

   task automatic check(input int req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] strobes();
      return {3'b000, life_start, life_reset, life_apply, life_end, life_term};
   endfunction

   task automatic drive(input logic en, input logic fl, input logic iv,
                        input logic ic, input logic [DW-1:0] d, input logic ordy);
      enable = en; flush = fl; in_valid = iv; in_ctrl = ic;
      in_data = d; out_ready = ordy;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: one vector per clock cycle
      for (int i = 0; i < NVEC; i++) begin
         logic [VW-1:0] v;
         int            rq;
         v  = VEC[i];
         rq = int'(v[33:30]);
         if (i != 0) @(negedge clk);
         drive(v[29], v[28], v[27], v[26], v[25:18], v[17]);
         #1;
         check(rq, "in_ready",  {7'd0, in_ready},  {7'd0, v[16]});
         check(rq, "out_valid", {7'd0, out_valid}, {7'd0, v[15]});
         if (v[15]) begin
            check(rq, "out_data",  out_data,          v[14:7]);   // R11
            check(rq, "out_first", {7'd0, out_first}, {7'd0, v[6]});
            check(rq, "out_last",  {7'd0, out_last},  {7'd0, v[5]});
         end
         check(rq, "strobes", strobes(), {3'b000, v[4:0]});
      end

      // R1: reset state after a second reset
      do_reset();
      #1;
      check(1, "in_ready after reset",  {7'd0, in_ready},  8'd0);
      check(1, "out_valid after reset", {7'd0, out_valid}, 8'd0);
      check(1, "strobes after reset",   strobes(),         8'd0);

      // R2: start once while enable stays high
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      #1;
      check(2, "start on enable", strobes(), 8'h10);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         #1;
         check(2, "no repeated start", strobes(), 8'd0);
         check(2, "ready after start", {7'd0, in_ready}, 8'd1);
      end

      // R9: flush with no open segment terminates two cycles later
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1);
      #1;
      check(9, "flush blocks input", {7'd0, in_ready}, 8'd0);
      check(9, "flush cycle strobes", strobes(), 8'd0);
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      #1;
      check(9, "empty close no beat", {7'd0, out_valid}, 8'd0);
      check(9, "empty close strobes", strobes(), 8'd0);
      @(negedge clk);
      #1;
      check(9, "terminate", strobes(), 8'h01);
      // R10: stays quiet after terminate
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hBB, 1'b1);
      #1;
      check(10, "quiet in_ready", {7'd0, in_ready}, 8'd0);
      check(10, "quiet strobes",  strobes(),        8'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule